// File: doc/BRIEF.md
# Answer-Tone Timing Qualifier

This block decides whether a fax or modem answer tone is present on one voice channel. The filter bank outside the block supplies two things for each of the receive and transmit paths. The first is a flag that is high when the in-band energy beats the out-of-band energy. The second is the signal level, coded as attenuation below 0 dBm in 0.2 dB steps. The block checks that level against a ceiling and a floor, picks one path, and qualifies the result against a 1 ms timebase. Each millisecond the selected path is either "tone" or "no tone".

A detect flag rises after enough tone time has built up. Short dropouts during the build-up are forgiven. The flag falls after enough silence has built up, and short bursts of tone during that silence are forgiven. Four 8-bit timing fields set these windows, each with its own time per count. A select bit chooses the built-in level limits or limits loaded by the user.

Top module: `tone_qualifier`

## Requirements
- R1: After reset `tone_detected` is 0. While `cfg_en` is 0 the flag stays 0 whatever tone the paths carry.
- R2: In a given millisecond the selected path carries tone only when its band flag is 1 and its level code L satisfies ceiling <= L <= floor. Level codes are attenuation in 0.2 dB steps, so code 0 is 0 dBm and code 150 is -30 dBm.
- R3: With `cfg_use_default`=1 the limits are ceiling code 30 (-6 dBm) and floor code 90 (-18 dBm). With `cfg_use_default`=0 the limits are `cfg_user_ceil` and `cfg_user_floor`.
- R4: From the cleared state, `tone_detected` rises on the tick that brings the accumulated tone time to `cfg_rec_time`*16 ms. It does not rise earlier. Ticks without tone do not add to this total.
- R5: While the flag is 0, a run of tone-free ticks that is no longer than `cfg_rec_gap`*4 ms keeps the accumulated tone time. The first tone-free tick beyond that length sets the accumulated tone time to zero.
- R6: Once the flag is 1, it falls on the tick that brings the accumulated tone-free time to `cfg_end_time`*4 ms.
- R7: While the flag is 1, a run of tone ticks no longer than `cfg_end_gap`*1 ms keeps the accumulated tone-free time. The first tone tick beyond that length sets it to zero.
- R8: `cfg_src_tx`=0 monitors the receive path and 1 monitors the transmit path. A change of the select bit clears the flag and all timing on the next clock.
- R9: Setting `cfg_en` to 0 clears the flag and all timing on the next clock.
- R10: Timing and the flag change only on clocks where `tick_ms` is 1, apart from the clears in R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-clock pulse per millisecond |
| cfg_en | input | 1 | Unit enable |
| cfg_src_tx | input | 1 | Path select: 0 receive, 1 transmit |
| cfg_use_default | input | 1 | 1 selects built-in level limits, 0 selects user limits |
| cfg_rec_time | input | 8 | Recognition time, 16 ms per count |
| cfg_rec_gap | input | 8 | Dropout tolerance while recognising, 4 ms per count |
| cfg_end_time | input | 8 | Silence time that ends detection, 4 ms per count |
| cfg_end_gap | input | 8 | Burst tolerance while ending, 1 ms per count |
| cfg_user_ceil | input | 8 | User ceiling level code |
| cfg_user_floor | input | 8 | User floor level code |
| rx_band_win | input | 1 | Receive path: in-band energy exceeds out-of-band |
| rx_level | input | 8 | Receive path level code |
| tx_band_win | input | 1 | Transmit path: in-band energy exceeds out-of-band |
| tx_level | input | 8 | Transmit path level code |
| tone_detected | output | 1 | Qualified tone flag |

## Verification
Two pairs of events can fall in the same cycle. A millisecond tick can coincide with the tick where a dropout becomes too long, or with the tick where the accumulated time reaches its limit. The bench provokes both with exact runs that end one tick short of a limit, exactly on it, and one tick past it, and the expected flag is worked out from the requirement arithmetic. The bench also changes the path select or drops the enable while tone is held. It then expects the clear to win on the very next clock with no tick present, and expects the following recognition to begin again from zero.

// File: rtl/tone_qual_pkg.sv
package tone_qual_pkg;

   typedef enum logic {
      Q_HUNT = 1'b0,
      Q_HELD = 1'b1
   } qual_state_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/tone_level_gate.sv
module tone_level_gate #(
   parameter int LVL_W     = 8,
   parameter int DEF_CEIL  = 30,
   parameter int DEF_FLOOR = 90
) (
   input  logic             use_default,
   input  logic [LVL_W-1:0] user_ceil,
   input  logic [LVL_W-1:0] user_floor,
   input  logic             band_win,
   input  logic [LVL_W-1:0] level,
   output logic             tone_ok
);

   localparam logic [LVL_W-1:0] CEIL_K  = LVL_W'(DEF_CEIL);
   localparam logic [LVL_W-1:0] FLOOR_K = LVL_W'(DEF_FLOOR);

   logic [LVL_W-1:0] lim_hi;
   logic [LVL_W-1:0] lim_lo;

   always_comb begin
      lim_hi  = use_default ? CEIL_K  : user_ceil;
      lim_lo  = use_default ? FLOOR_K : user_floor;
      tone_ok = band_win && (level >= lim_hi) && (level <= lim_lo);
   end

endmodule

// File: rtl/tone_qual_timer.sv
module tone_qual_timer
   import tone_qual_pkg::*;
#(
   parameter int FIELD_W   = 8,
   parameter int SCALE_RT  = 16,
   parameter int SCALE_RBK = 4,
   parameter int SCALE_ET  = 4,
   parameter int SCALE_EBK = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               tick,
   input  logic               tone,
   input  logic [FIELD_W-1:0] rec_time,
   input  logic [FIELD_W-1:0] rec_gap,
   input  logic [FIELD_W-1:0] end_time,
   input  logic [FIELD_W-1:0] end_gap,
   output logic               held
);

   localparam int MAX_SCALE = max4(SCALE_RT, SCALE_RBK, SCALE_ET, SCALE_EBK);
   localparam int CNT_W     = $clog2(((1 << FIELD_W) - 1) * MAX_SCALE + 2);

   qual_state_e state_q;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] brk_q;
   logic [CNT_W-1:0] run_inc;
   logic [CNT_W-1:0] brk_inc;
   logic [CNT_W-1:0] run_lim;
   logic [CNT_W-1:0] brk_lim;
   logic             counts_now;

   always_comb begin
      run_inc = run_q + 1'b1;
      brk_inc = brk_q + 1'b1;
      if (state_q == Q_HUNT) begin
         run_lim    = CNT_W'(rec_time) * CNT_W'(SCALE_RT);
         brk_lim    = CNT_W'(rec_gap)  * CNT_W'(SCALE_RBK);
         counts_now = tone;
      end else begin
         run_lim    = CNT_W'(end_time) * CNT_W'(SCALE_ET);
         brk_lim    = CNT_W'(end_gap)  * CNT_W'(SCALE_EBK);
         counts_now = !tone;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         state_q <= Q_HUNT;
         run_q   <= '0;
         brk_q   <= '0;
      end else if (tick) begin
         if (counts_now) begin
            brk_q <= '0;
            if (run_inc >= run_lim) begin
               state_q <= (state_q == Q_HUNT) ? Q_HELD : Q_HUNT;
               run_q   <= '0;
            end else begin
               run_q <= run_inc;
            end
         end else if (brk_inc > brk_lim) begin
            run_q <= '0;
            brk_q <= '0;
         end else begin
            brk_q <= brk_inc;
         end
      end
   end

   assign held = (state_q == Q_HELD);

endmodule

// File: rtl/tone_qualifier.sv
module tone_qualifier #(
   parameter int FIELD_W   = 8,
   parameter int LVL_W     = 8,
   parameter int SCALE_RT  = 16,
   parameter int SCALE_RBK = 4,
   parameter int SCALE_ET  = 4,
   parameter int SCALE_EBK = 1,
   parameter int DEF_CEIL  = 30,
   parameter int DEF_FLOOR = 90
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_ms,
   input  logic               cfg_en,
   input  logic               cfg_src_tx,
   input  logic               cfg_use_default,
   input  logic [FIELD_W-1:0] cfg_rec_time,
   input  logic [FIELD_W-1:0] cfg_rec_gap,
   input  logic [FIELD_W-1:0] cfg_end_time,
   input  logic [FIELD_W-1:0] cfg_end_gap,
   input  logic [LVL_W-1:0]   cfg_user_ceil,
   input  logic [LVL_W-1:0]   cfg_user_floor,
   input  logic               rx_band_win,
   input  logic [LVL_W-1:0]   rx_level,
   input  logic               tx_band_win,
   input  logic [LVL_W-1:0]   tx_level,
   output logic               tone_detected
);

   localparam int NPATH = 2;

   if (FIELD_W < 1 || LVL_W < 1) begin : g_bad_width
      $error("tone_qualifier: widths must be positive");
   end
   if (SCALE_RT < 1 || SCALE_RBK < 1 || SCALE_ET < 1 || SCALE_EBK < 1) begin : g_bad_scale
      $error("tone_qualifier: scale factors must be at least 1");
   end
   if (DEF_CEIL > DEF_FLOOR || DEF_FLOOR >= (1 << LVL_W)) begin : g_bad_limits
      $error("tone_qualifier: default level limits out of order or range");
   end

   logic [NPATH-1:0] band_v;
   logic [LVL_W-1:0] level_v [NPATH];
   logic [NPATH-1:0] path_tone;
   logic             tone_sel;
   logic             src_q;
   logic             clr;

   assign band_v[0]  = rx_band_win;
   assign band_v[1]  = tx_band_win;
   assign level_v[0] = rx_level;
   assign level_v[1] = tx_level;

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      tone_level_gate #(
         .LVL_W    (LVL_W),
         .DEF_CEIL (DEF_CEIL),
         .DEF_FLOOR(DEF_FLOOR)
      ) u_gate (
         .use_default(cfg_use_default),
         .user_ceil  (cfg_user_ceil),
         .user_floor (cfg_user_floor),
         .band_win   (band_v[p]),
         .level      (level_v[p]),
         .tone_ok    (path_tone[p])
      );
   end

   assign tone_sel = cfg_src_tx ? path_tone[1] : path_tone[0];

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= cfg_src_tx;
   end

   assign clr = !cfg_en || (cfg_src_tx != src_q);

   tone_qual_timer #(
      .FIELD_W  (FIELD_W),
      .SCALE_RT (SCALE_RT),
      .SCALE_RBK(SCALE_RBK),
      .SCALE_ET (SCALE_ET),
      .SCALE_EBK(SCALE_EBK)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .tick    (tick_ms),
      .tone    (tone_sel),
      .rec_time(cfg_rec_time),
      .rec_gap (cfg_rec_gap),
      .end_time(cfg_end_time),
      .end_gap (cfg_end_gap),
      .held    (tone_detected)
   );

endmodule

// File: rtl/tone_qualifier_chk.sv
module tone_qualifier_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_ms,
   input logic cfg_en,
   input logic cfg_src_tx,
   input logic tone_now,
   input logic tone_detected
);

   a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !tone_detected);

   a_r8_src_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src_tx != $past(cfg_src_tx)) |=> !tone_detected);

   a_r10_change_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_ms && cfg_en && $stable(cfg_src_tx)) |=> $stable(tone_detected));

   a_r4_rise_on_tone_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tone_detected) |-> ($past(tick_ms) && $past(tone_now) && $past(cfg_en)));

   a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tone_detected) |-> ($past(!tone_now && tick_ms) || $past(!cfg_en)
                                 || ($past(cfg_src_tx) != $past(cfg_src_tx, 2))));

   a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && $past(!cfg_en)) |-> !tone_detected);

endmodule

bind tone_qualifier tone_qualifier_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_ms      (tick_ms),
   .cfg_en       (cfg_en),
   .cfg_src_tx   (cfg_src_tx),
   .tone_now     (tone_sel),
   .tone_detected(tone_detected)
);

// File: tb/tone_qualifier_tb.sv
module tone_qualifier_tb;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic       cfg_en = 1'b0;
   logic       cfg_src_tx = 1'b0;
   logic       cfg_use_default = 1'b1;
   logic [7:0] cfg_rec_time = 8'd1;
   logic [7:0] cfg_rec_gap = 8'd1;
   logic [7:0] cfg_end_time = 8'd2;
   logic [7:0] cfg_end_gap = 8'd2;
   logic [7:0] cfg_user_ceil = 8'd10;
   logic [7:0] cfg_user_floor = 8'd40;
   logic       rx_band_win = 1'b0;
   logic [7:0] rx_level = 8'd60;
   logic       tx_band_win = 1'b0;
   logic [7:0] tx_level = 8'd60;
   logic       tone_detected;

   typedef struct {
      logic  val;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 0;

   always #(CLK_P/2) clk = ~clk;

   tone_qualifier u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .cfg_en(cfg_en),
      .cfg_src_tx(cfg_src_tx), .cfg_use_default(cfg_use_default),
      .cfg_rec_time(cfg_rec_time), .cfg_rec_gap(cfg_rec_gap),
      .cfg_end_time(cfg_end_time), .cfg_end_gap(cfg_end_gap),
      .cfg_user_ceil(cfg_user_ceil), .cfg_user_floor(cfg_user_floor),
      .rx_band_win(rx_band_win), .rx_level(rx_level),
      .tx_band_win(tx_band_win), .tx_level(tx_level),
      .tone_detected(tone_detected)
   );

   // monitor: pops expectations a quarter period after each rising edge
   always begin
      @(posedge clk);
      #(CLK_P/4);
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         total++;
         if (tone_detected !== e.val) begin
            bad++;
            $display("FAIL %s: tone_detected=%0b expected=%0b", e.tag, tone_detected, e.val);
         end
      end
   end

   task automatic expect_flag(input logic v, input string tag);
      exp_t e;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic paths(input logic rb, input logic [7:0] rl,
                        input logic tb, input logic [7:0] tl);
      @(negedge clk);
      rx_band_win = rb; rx_level = rl; tx_band_win = tb; tx_level = tl;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_ms = 1'b1;
         @(negedge clk); tick_ms = 1'b0;
      end
   endtask

   task automatic on_rx(input int n);  paths(1'b1, 8'd60, 1'b0, 8'd60); ticks(n); endtask
   task automatic off_rx(input int n); paths(1'b0, 8'd60, 1'b0, 8'd60); ticks(n); endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_flag(1'b0, "R1 reset state");
      rst_n = 1'b1;
      // R1: disabled unit ignores tone even with zero recognition time
      cfg_rec_time = 8'd0;
      on_rx(5);
      expect_flag(1'b0, "R1 disabled ignores tone");
      cfg_rec_time = 8'd1;
      @(negedge clk); cfg_en = 1'b1;
      @(negedge clk);
      // R4: 16 ms recognition
      on_rx(15);
      expect_flag(1'b0, "R4 one tick short");
      ticks(1);
      expect_flag(1'b1, "R4 reached 16 ms");
      // R6: 8 ms end time
      off_rx(7);
      expect_flag(1'b1, "R6 one tick short of end");
      ticks(1);
      expect_flag(1'b0, "R6 ended at 8 ms");
      // R5: gap of 4 ms forgiven
      on_rx(10); off_rx(4); on_rx(5);
      expect_flag(1'b0, "R5 tolerated gap, 15 ms tone");
      ticks(1);
      expect_flag(1'b1, "R5 tolerated gap keeps count");
      off_rx(8);
      expect_flag(1'b0, "R6 end before R5 restart case");
      // R5: gap of 5 ms restarts
      on_rx(10); off_rx(5); on_rx(15);
      expect_flag(1'b0, "R5 long gap restarted count");
      ticks(1);
      expect_flag(1'b1, "R5 recognised after restart");
      // R7: 2 ms burst forgiven
      off_rx(6); on_rx(2); off_rx(1);
      expect_flag(1'b1, "R7 tolerated burst, 7 ms silence");
      ticks(1);
      expect_flag(1'b0, "R7 tolerated burst keeps count");
      // R7: 3 ms burst restarts
      on_rx(16);
      expect_flag(1'b1, "R7 setup");
      off_rx(6); on_rx(3); off_rx(7);
      expect_flag(1'b1, "R7 long burst restarted count");
      ticks(1);
      expect_flag(1'b0, "R7 ended after restart");
      // R8: transmit path select
      @(negedge clk); cfg_src_tx = 1'b1;
      @(negedge clk);
      paths(1'b0, 8'd60, 1'b1, 8'd60); ticks(16);
      expect_flag(1'b1, "R8 transmit path recognised");
      @(negedge clk); cfg_src_tx = 1'b0;
      @(negedge clk);
      expect_flag(1'b0, "R8 source change clears");
      @(negedge clk); cfg_src_tx = 1'b1;
      @(negedge clk);
      ticks(15);
      expect_flag(1'b0, "R8 count restarted after change");
      ticks(1);
      expect_flag(1'b1, "R8 recognised from zero");
      // R9 and R10
      @(negedge clk); cfg_en = 1'b0;
      @(negedge clk);
      expect_flag(1'b0, "R9 disable clears");
      @(negedge clk); cfg_en = 1'b1;
      repeat (40) @(negedge clk);
      expect_flag(1'b0, "R10 no change without tick");
      ticks(15);
      expect_flag(1'b0, "R9 count cleared by disable");
      // R2: level above ceiling, and band flag low
      @(negedge clk); cfg_src_tx = 1'b0;
      @(negedge clk);
      paths(1'b1, 8'd20, 1'b0, 8'd60); ticks(20);
      expect_flag(1'b0, "R2 level above default ceiling");
      paths(1'b0, 8'd60, 1'b1, 8'd60); ticks(20);
      expect_flag(1'b0, "R2 band flag low");
      paths(1'b1, 8'd91, 1'b0, 8'd60); ticks(20);
      expect_flag(1'b0, "R3 below default floor");
      paths(1'b1, 8'd30, 1'b0, 8'd60); ticks(8);
      paths(1'b1, 8'd90, 1'b0, 8'd60); ticks(8);
      expect_flag(1'b1, "R3 default limits inclusive");
      off_rx(8);
      expect_flag(1'b0, "R6 end before R3 user case");
      // R3: user limits 10..40
      @(negedge clk); cfg_use_default = 1'b0;
      paths(1'b1, 8'd60, 1'b0, 8'd60); ticks(20);
      expect_flag(1'b0, "R3 level 60 outside user limits");
      paths(1'b1, 8'd20, 1'b0, 8'd60); ticks(16);
      expect_flag(1'b1, "R3 level 20 inside user limits");
      repeat (4) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule